// File: doc/BRIEF.md
# Burst Window Register Redirector

This block is the front end of a small peripheral register file. It lets a DMA engine step through a run of consecutive registers while always using one fixed window address. A bank of 16-bit registers sits at the bottom of the address map, at word offsets 0x00 upward. A steering register holds two values: a base register index and a burst length. Every read or write to the window address is sent to register `base + step`. After each such access the step counter moves on by one.

The step counter runs from 0 up to the programmed length value and then returns to 0. A burst of identical window accesses therefore covers `length + 1` successive real registers and then starts again at the base. Any write to the steering register sets the counter back to 0. A redirected access that lands on an offset with no register behind it reads as zero and changes nothing, and so does one that lands on the window itself. The counter still advances in both cases.

The bus is word-aligned and byte-addressed; the low two address bits are ignored. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe. If no read is issued, the read data holds its last value.

Top module: `burst_window_regfile`

## Requirements
- R1: After reset, every bank register reads 0x0000, the steering register reads 0x0000, the step counter is 0, and `rd_data` is 0x0000.
- R2: The steering register sits at byte offset 0x48. Its bits 12:8 hold the burst length and its bits 4:0 hold the base index. Both fields read back as written, one cycle after the read strobe.
- R3: Bits 15:13 and 7:5 of the steering register always read as zero, whatever value is written to them.
- R4: Bank register k (k = 0 to 17) is reached directly at byte offset 4·k and holds full 16-bit data. A direct access to any offset that has no register behind it (for example 0x50) reads as zero and stores nothing.
- R5: A write to the window offset 0x4C stores the full 16-bit write data into the register with word index `base + step`.
- R6: A read of the window offset returns the contents of the register with word index `base + step`.
- R7: Each window access, read or write, advances the step counter by one. After the access with step equal to the length value, the counter returns to 0. A length value L therefore gives bursts of L+1 transfers, up to 18 transfers at L = 17.
- R8: Any write to the steering register, including one that arrives through the window, sets the step counter to 0.
- R9: A window access whose target index has no register behind it reads as zero and ignores the write data. This covers a target equal to the window's own index, 19, and any index from 20 up. The step counter still advances. A target index of 18 reaches the steering register.
- R10: Idle cycles and accesses to any offset other than the window leave the step counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Byte address; bits 1:0 ignored |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data, valid one cycle after `rd_en` |

## Verification
Several behaviours are checked by assertions on every cycle:
- the step counter never exceeds the length value;
- the counter returns to zero after a steering write or after the last transfer of a burst;
- the counter moves by exactly one on every other window access;
- the counter holds still when the window is not accessed;
- bank registers change only when they are the selected write target;
- steering reads show zero in the reserved bits;
- window reads aimed at the window's own index return zero.

Only the bench's scenarios can show that data truly lands in the register that the base and step select. The same holds for the other data-path behaviours:
- a full 18-transfer burst covers the whole bank;
- writes aimed at holes leave every real register intact;
- direct accesses interleaved with a burst do not disturb its position.

// File: rtl/bwr_pkg.sv
`timescale 1ns/1ps
package bwr_pkg;
    localparam int DATA_W   = 16;
    localparam int LEN_W    = 5;
    localparam int BASE_W   = 5;
    localparam int LEN_LSB  = 8;
    localparam int BASE_LSB = 0;
    localparam int TGT_W    = BASE_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [BASE_W-1:0] base;
        logic [LEN_W-1:0]  step;
    } steer_state_t;
endpackage

// File: rtl/bwr_steer.sv
`timescale 1ns/1ps
module bwr_steer
    import bwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              steer_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_acc,
    output logic [DATA_W-1:0] steer_rd,
    output logic [TGT_W-1:0]  target
);
    steer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (steer_we) begin
            st_d.len  = wr_data[LEN_LSB +: LEN_W];
            st_d.base = wr_data[BASE_LSB +: BASE_W];
            st_d.step = '0;
        end else if (win_acc) begin
            if (st_q.step >= st_q.len) st_d.step = '0;
            else                       st_d.step = st_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        steer_rd = '0;
        steer_rd[LEN_LSB +: LEN_W]   = st_q.len;
        steer_rd[BASE_LSB +: BASE_W] = st_q.base;
    end

    assign target = TGT_W'(st_q.base) + TGT_W'(st_q.step);

    assert_step_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step <= st_q.len);
    assert_steer_clears_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        steer_we |=> st_q.step == '0);
    assert_burst_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !steer_we && st_q.step == st_q.len) |=> st_q.step == '0);
    assert_step_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !steer_we && st_q.step < st_q.len) |=> st_q.step == $past(st_q.step) + 1'b1);
    assert_step_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_acc && !steer_we) |=> $stable(st_q.step));
endmodule

// File: rtl/bwr_bank.sv
`timescale 1ns/1ps
module bwr_bank #(
    parameter int N_REGS = 18,
    parameter int DATA_W = 16,
    localparam int SEL_W = $clog2(N_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [SEL_W-1:0]               sel,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [N_REGS-1:0][DATA_W-1:0]  regs
);
    logic [N_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        always_comb begin
            regs_d[i] = regs_q[i];
            if (we && sel == SEL_W'(i)) regs_d[i] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[i] <= '0;
            else        regs_q[i] <= regs_d[i];
        end

        assert_reg_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel == SEL_W'(i)) |=> $stable(regs_q[i]));
    end

    assign regs = regs_q;
endmodule

// File: rtl/burst_window_regfile.sv
`timescale 1ns/1ps
module burst_window_regfile
    import bwr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int N_REGS    = 18,
    parameter int STEER_IDX = 18,
    parameter int WIN_IDX   = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int EFF_W  = (WORD_W > TGT_W) ? WORD_W : TGT_W;
    localparam int SEL_W  = $clog2(N_REGS);

    logic [WORD_W-1:0]             word;
    logic                          hit_win, win_acc;
    logic [TGT_W-1:0]              target;
    logic [EFF_W-1:0]              eff;
    logic                          eff_bank, eff_steer;
    logic                          bank_we, steer_we;
    logic [DATA_W-1:0]             steer_rd;
    logic [N_REGS-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]             rd_val;
    logic [DATA_W-1:0]             rd_data_d, rd_data_q;

    assign word      = addr[ADDR_W-1:2];
    assign hit_win   = (word == WORD_W'(WIN_IDX));
    assign win_acc   = hit_win && (wr_en || rd_en);
    assign eff       = hit_win ? EFF_W'(target) : EFF_W'(word);
    assign eff_bank  = (eff < EFF_W'(N_REGS));
    assign eff_steer = (eff == EFF_W'(STEER_IDX));
    assign bank_we   = wr_en && eff_bank;
    assign steer_we  = wr_en && eff_steer;

    bwr_steer u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .steer_we (steer_we),
        .wr_data  (wr_data),
        .win_acc  (win_acc),
        .steer_rd (steer_rd),
        .target   (target)
    );

    bwr_bank #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bank_we),
        .sel     (eff[SEL_W-1:0]),
        .wr_data (wr_data),
        .regs    (regs)
    );

    always_comb begin
        rd_val = '0;
        if (eff_steer)     rd_val = steer_rd;
        else if (eff_bank) rd_val = regs[eff[SEL_W-1:0]];
        rd_data_d = rd_en ? rd_val : rd_data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_data_d;
    end

    assign rd_data = rd_data_q;

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_win && word == WORD_W'(STEER_IDX)) |=> (rd_data[15:13] == '0 && rd_data[7:5] == '0));
    assert_self_target_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_win && target == TGT_W'(WIN_IDX)) |=> rd_data == '0);
    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/burst_window_regfile_test.sv
`timescale 1ns/1ps
module burst_window_regfile_test;
    localparam int NR = 18;
    localparam logic [7:0] STEER = 8'h48;
    localparam logic [7:0] WIN   = 8'h4C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [NR];
    logic [15:0] steer_model = '0;

    always #2.5 clk = ~clk;

    burst_window_regfile uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic set_steer(input logic [15:0] v);
        bus_wr(STEER, v);
        steer_model = v & 16'h1F1F;
    endtask

    task automatic check_reg(input string req, input int k);
        logic [15:0] d;
        bus_rd(8'(k * 4), d);
        check(req, d, model[k]);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 rd_data", rd_data, 16'h0000);
        bus_rd(STEER, d);   check("R1 steer", d, 16'h0000);
        bus_rd(8'h00, d);   check("R1 reg0", d, 16'h0000);
        bus_rd(8'h44, d);   check("R1 reg17", d, 16'h0000);
        bus_rd(WIN, d);     check("R1 window", d, 16'h0000);
    endtask

    task automatic t_steer_fields();
        logic [15:0] d;
        set_steer(16'hFFFF);
        bus_rd(STEER, d); check("R3 reserved bits", d, 16'h1F1F);
        set_steer(16'h0E0B);
        bus_rd(STEER, d); check("R2 fields", d, 16'h0E0B);
    endtask

    task automatic t_direct();
        logic [15:0] d;
        for (int k = 0; k < NR; k++) begin
            model[k] = 16'hA500 + 16'(k * 3);
            bus_wr(8'(k * 4), model[k]);
        end
        check_reg("R4 reg0", 0);
        check_reg("R4 reg9", 9);
        check_reg("R4 reg17", 17);
        bus_wr(8'h50, 16'h5A5A);
        bus_rd(8'h50, d); check("R4 unmapped", d, 16'h0000);
    endtask

    task automatic t_burst_write();
        set_steer(16'h0203);
        bus_wr(WIN, 16'h1234); model[3] = 16'h1234;
        bus_wr(WIN, 16'h5678); model[4] = 16'h5678;
        bus_wr(WIN, 16'h9ABC); model[5] = 16'h9ABC;
        check_reg("R5 reg2 untouched", 2);
        check_reg("R5 reg3", 3);
        check_reg("R5 reg4", 4);
        check_reg("R5 reg5", 5);
        check_reg("R5 reg6 untouched", 6);
    endtask

    task automatic t_burst_read();
        logic [15:0] d;
        set_steer(16'h0203);
        bus_rd(WIN, d); check("R6 step0", d, model[3]);
        bus_rd(WIN, d); check("R6 step1", d, model[4]);
        bus_rd(WIN, d); check("R6 step2", d, model[5]);
        bus_rd(WIN, d); check("R7 wrap to base", d, model[3]);
    endtask

    task automatic t_clear_and_idle();
        logic [15:0] d;
        set_steer(16'h0300);
        bus_rd(WIN, d); check("R6 reg0", d, model[0]);
        bus_rd(WIN, d); check("R6 reg1", d, model[1]);
        set_steer(16'h0300);
        bus_rd(WIN, d); check("R8 restart", d, model[0]);
        bus_rd(8'h14, d); check("R10 direct read", d, model[5]);
        bus_wr(8'h20, 16'h7777); model[8] = 16'h7777;
        repeat (3) @(negedge clk);
        bus_rd(WIN, d); check("R10 step kept", d, model[1]);
    endtask

    task automatic t_holes();
        logic [15:0] d;
        set_steer(16'h0211);
        bus_rd(WIN, d); check("R9 reg17", d, model[17]);
        bus_rd(WIN, d); check("R9 steer via window", d, 16'h0211);
        bus_rd(WIN, d); check("R9 window self", d, 16'h0000);
        bus_rd(WIN, d); check("R9 advanced past hole", d, model[17]);
        set_steer(16'h0013);
        bus_wr(WIN, 16'hFFFF);
        set_steer(16'h0019);
        bus_wr(WIN, 16'hEEEE);
        bus_rd(WIN, d); check("R9 beyond bank", d, 16'h0000);
        bus_rd(STEER, d); check("R9 steer intact", d, 16'h0019);
        for (int k = 0; k < NR; k++) check_reg("R9 bank intact", k);
    endtask

    task automatic t_full_burst();
        logic [15:0] d;
        set_steer(16'h1100);
        for (int k = 0; k < NR; k++) begin
            model[k] = 16'hC000 ^ 16'(k * 257);
            bus_wr(WIN, model[k]);
        end
        for (int k = 0; k < NR; k++) check_reg("R7 18-transfer burst", k);
        bus_rd(WIN, d); check("R7 wrap after 18", d, model[0]);
    endtask

    initial begin
        for (int k = 0; k < NR; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_steer_fields();
        t_direct();
        t_burst_write();
        t_burst_read();
        t_clear_and_idle();
        t_holes();
        t_full_burst();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule